// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the bus writes that reach one byte-wide NOR flash device with eight 64K-byte sectors. It is a synchronous model: the host side presents a one-cycle write strobe with the sampled address and data. Every command starts with a two-write unlock prefix. The decoder then walks through read, identification, program, erase-setup, sector-collection and erase states, and supports suspend and resume of a running erase.

The block drives a small engine interface. It gives a start pulse, the operation kind, a sector mask, and the program target address and data. A parameterised busy counter stands in for the real cell timing and produces the done pulse. A combinational read port returns array data, identification codes or polling status, depending on the state. The host polls bit 7 to learn when an operation has finished.

Timing is counted in clock cycles. The window length and both busy durations are parameters, so a simulation runs in a few thousand cycles instead of seconds.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in plain read mode. `rd_data` equals `arr_rdata`, `eng_busy`, `eng_start` and `eng_hold` are 0, and `eng_sector_mask` is all zeros.
- R2: The unlock prefix is data AAh at an address whose low 16 bits are AAAAh, followed by data 55h at low bits 5554h. Address bits above bit 15 are ignored for unlock and command writes. A write with the wrong address or data at any point of the prefix drops the decoder back to idle, and it starts no operation.
- R3: Prefix plus 90h at AAAAh enters identification mode. There, read offset 00h returns 01h, offset 02h returns A4h, and any other offset returns 00h. A broken prefix stays in identification mode. Only prefix plus F0h leaves it, returning to array reads.
- R4: Prefix plus A0h arms a program. The next write then raises `eng_start` for exactly one cycle with `eng_erase`=0, and captures that write's address on `eng_addr` and its data on `eng_data`.
- R5: While a program is busy, `rd_data` reads {~data bit 7, 7'b0}, and every write is ignored. `eng_done` is high in the PROG_CYC-th busy cycle, and array reads resume on the following cycle.
- R6: Prefix plus 80h, a second prefix, and then 10h at AAAAh start an erase of the whole device. This raises `eng_start` with `eng_erase`=1 and a mask of all ones.
- R7: Prefix plus 80h, a second prefix, and then 30h at any address set the sector bit selected by address bits [18:16] and open the collection window. Each further 30h write adds its sector and restarts the window. The erase starts when WINDOW_CYC clock edges pass after the last 30h write with no further write: `eng_start` is high in the cycle that follows the WINDOW_CYC-th edge.
- R8: A write with any data other than 30h inside the window cancels the pending erase. The mask clears, no start follows, and the decoder returns to array reads.
- R9: While an erase runs, `rd_data` is 00h (bit 7 low). After ERASE_CYC cycles, `eng_done` pulses and array reads resume.
- R10: Data B0h written at any address during a running erase sets `eng_hold` and freezes the busy count. While suspended, reads of sectors outside the mask return `arr_rdata` and reads inside it return 00h. Data 30h resumes the erase.
- R11: Data F0h written during a running or suspended erase stops it at once: `eng_busy` falls, no `eng_done` pulse follows, and array reads resume.
- R12: A 30h write sampled in the same cycle the window would expire restarts the window, and no start occurs. A B0h write sampled in the cycle `eng_done` is high is ignored: the erase completes and `eng_hold` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data or command byte of the write |
| rd_addr | input | ADDR_W | Byte address being read |
| arr_rdata | input | 8 | Array contents at `rd_addr` |
| rd_data | output | 8 | Read result: array, identification or polling status |
| eng_start | output | 1 | One-cycle start of a program or erase |
| eng_erase | output | 1 | 1 for erase, 0 for program |
| eng_sector_mask | output | 8 | Sectors selected for erase |
| eng_addr | output | ADDR_W | Program target address |
| eng_data | output | 8 | Program data |
| eng_hold | output | 1 | Erase is suspended |
| eng_busy | output | 1 | Operation in progress |
| eng_done | output | 1 | Operation completes in this cycle |

## Verification
Two collisions can fall in the same cycle. The first is a fresh 30h write landing on the exact edge where the collection window would expire. The bench times the second sector write to the WINDOW_CYC-th edge after the first. It checks that no start appears, that both sector bits are held, and that the start comes a full window after the second write. The second collision is a suspend request landing on the erase's final busy cycle. The bench first confirms that `eng_done` is high, then writes B0h on that edge and judges that the erase ends normally, with `eng_hold` low and array reads restored.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_UNL1,
    PH_UNL2,
    PH_PROG_ARM,
    PH_ERS_SETUP,
    PH_ERS_UNL1,
    PH_ERS_UNL2,
    PH_WINDOW,
    PH_PROG_BUSY,
    PH_ERS_BUSY,
    PH_ERS_SUSP
  } fcd_phase_e;

  typedef enum logic [2:0] {
    SRC_ARRAY,
    SRC_IDENT,
    SRC_PROG,
    SRC_ERASE,
    SRC_SUSP
  } fcd_src_e;

  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [15:0] KEY_ADR_A   = 16'hAAAA;
  localparam logic [15:0] KEY_ADR_B   = 16'h5554;

  localparam logic [7:0]  OP_RESET    = 8'hF0;
  localparam logic [7:0]  OP_IDENT    = 8'h90;
  localparam logic [7:0]  OP_PROGRAM  = 8'hA0;
  localparam logic [7:0]  OP_ERS_PREP = 8'h80;
  localparam logic [7:0]  OP_ERS_ALL  = 8'h10;
  localparam logic [7:0]  OP_ERS_SECT = 8'h30;
  localparam logic [7:0]  OP_SUSPEND  = 8'hB0;

  localparam logic [7:0]  ID_MAKER    = 8'h01;
  localparam logic [7:0]  ID_PART     = 8'hA4;

endpackage

// File: rtl/fcd_window_timer.sv
module fcd_window_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && !restart && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (run && !expired)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fcd_busy_engine.sv
module fcd_busy_engine #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kind_erase,
  input  logic pause,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q;
  logic          erase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = erase_q ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
  assign busy = busy_q;
  assign done = busy_q && !pause && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (abort) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      erase_q <= kind_erase;
      cnt_q   <= '0;
    end else if (done) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (busy_q && !pause) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3,
  parameter int NSECT  = 8
) (
  input  fcd_src_e          src,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  input  logic              prog_bit7,
  input  logic [NSECT-1:0]  mask,
  output logic [7:0]        rd_data
);
  localparam int OFS_W = ADDR_W - SECT_W;

  logic [SECT_W-1:0] rd_sect;
  logic [OFS_W-1:0]  rd_ofs;
  logic              in_erase;

  assign rd_sect  = rd_addr[ADDR_W-1 -: SECT_W];
  assign rd_ofs   = rd_addr[OFS_W-1:0];
  assign in_erase = mask[rd_sect];

  always_comb begin
    case (src)
      SRC_IDENT: begin
        if (rd_ofs == OFS_W'(0))      rd_data = ID_MAKER;
        else if (rd_ofs == OFS_W'(2)) rd_data = ID_PART;
        else                          rd_data = 8'h00;
      end
      SRC_PROG:  rd_data = {~prog_bit7, 7'b0};
      SRC_ERASE: rd_data = 8'h00;
      SRC_SUSP:  rd_data = in_erase ? 8'h00 : arr_rdata;
      default:   rd_data = arr_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECT_W     = 3,
  parameter int WINDOW_CYC = 6400,
  parameter int PROG_CYC   = 1024,
  parameter int ERASE_CYC  = 65536
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [7:0]               arr_rdata,
  output logic [7:0]               rd_data,
  output logic                     eng_start,
  output logic                     eng_erase,
  output logic [(1<<SECT_W)-1:0]   eng_sector_mask,
  output logic [ADDR_W-1:0]        eng_addr,
  output logic [7:0]               eng_data,
  output logic                     eng_hold,
  output logic                     eng_busy,
  output logic                     eng_done
);
  localparam int NSECT = 1 << SECT_W;

  fcd_phase_e        ph_q, ph_n;
  logic              ident_q, ident_n;
  logic              start_q, start_n;
  logic              erase_q, erase_n;
  logic [NSECT-1:0]  mask_q, mask_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [7:0]        data_q, data_n;
  logic              abort;
  logic              win_restart;
  logic              win_expired;
  logic              eng_done_w;
  logic              eng_busy_w;
  fcd_src_e          src;

  logic [SECT_W-1:0] wr_sect;
  logic [NSECT-1:0]  wr_onehot;
  logic              key_a, key_b;

  assign wr_sect = wr_addr[ADDR_W-1 -: SECT_W];
  for (genvar s = 0; s < NSECT; s++) begin : g_sect_dec
    assign wr_onehot[s] = (wr_sect == SECT_W'(s));
  end

  assign key_a = (wr_addr[15:0] == KEY_ADR_A);
  assign key_b = (wr_addr[15:0] == KEY_ADR_B);

  assign win_restart = wr_stb && (wr_data == OP_ERS_SECT) &&
                       ((ph_q == PH_ERS_UNL2) || (ph_q == PH_WINDOW));

  always_comb begin
    ph_n    = ph_q;
    ident_n = ident_q;
    start_n = 1'b0;
    erase_n = erase_q;
    mask_n  = mask_q;
    addr_n  = addr_q;
    data_n  = data_q;
    abort   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (wr_stb && key_a && wr_data == KEY_FIRST) ph_n = PH_UNL1;
      end
      PH_UNL1: begin
        if (wr_stb) ph_n = (key_b && wr_data == KEY_SECOND) ? PH_UNL2 : PH_IDLE;
      end
      PH_UNL2: begin
        if (wr_stb) begin
          ph_n = PH_IDLE;
          if (key_a) begin
            if (ident_q) begin
              if (wr_data == OP_RESET) ident_n = 1'b0;
            end else begin
              case (wr_data)
                OP_IDENT:    ident_n = 1'b1;
                OP_PROGRAM:  ph_n    = PH_PROG_ARM;
                OP_ERS_PREP: ph_n    = PH_ERS_SETUP;
                default:     ph_n    = PH_IDLE;
              endcase
            end
          end
        end
      end
      PH_PROG_ARM: begin
        if (wr_stb) begin
          ph_n    = PH_PROG_BUSY;
          start_n = 1'b1;
          erase_n = 1'b0;
          addr_n  = wr_addr;
          data_n  = wr_data;
          mask_n  = '0;
        end
      end
      PH_ERS_SETUP: begin
        if (wr_stb) ph_n = (key_a && wr_data == KEY_FIRST) ? PH_ERS_UNL1 : PH_IDLE;
      end
      PH_ERS_UNL1: begin
        if (wr_stb) ph_n = (key_b && wr_data == KEY_SECOND) ? PH_ERS_UNL2 : PH_IDLE;
      end
      PH_ERS_UNL2: begin
        if (wr_stb) begin
          if (key_a && wr_data == OP_ERS_ALL) begin
            ph_n    = PH_ERS_BUSY;
            start_n = 1'b1;
            erase_n = 1'b1;
            mask_n  = '1;
          end else if (wr_data == OP_ERS_SECT) begin
            ph_n    = PH_WINDOW;
            mask_n  = wr_onehot;
          end else begin
            ph_n    = PH_IDLE;
          end
        end
      end
      PH_WINDOW: begin
        if (wr_stb) begin
          if (wr_data == OP_ERS_SECT) begin
            mask_n = mask_q | wr_onehot;
          end else begin
            ph_n   = PH_IDLE;
            mask_n = '0;
          end
        end else if (win_expired) begin
          ph_n    = PH_ERS_BUSY;
          start_n = 1'b1;
          erase_n = 1'b1;
        end
      end
      PH_PROG_BUSY: begin
        if (eng_done_w) ph_n = PH_IDLE;
      end
      PH_ERS_BUSY: begin
        if (eng_done_w) begin
          ph_n   = PH_IDLE;
          mask_n = '0;
        end else if (wr_stb && wr_data == OP_RESET) begin
          ph_n   = PH_IDLE;
          mask_n = '0;
          abort  = 1'b1;
        end else if (wr_stb && wr_data == OP_SUSPEND) begin
          ph_n   = PH_ERS_SUSP;
        end
      end
      PH_ERS_SUSP: begin
        if (wr_stb && wr_data == OP_ERS_SECT) begin
          ph_n   = PH_ERS_BUSY;
        end else if (wr_stb && wr_data == OP_RESET) begin
          ph_n   = PH_IDLE;
          mask_n = '0;
          abort  = 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      ident_q <= 1'b0;
      start_q <= 1'b0;
      erase_q <= 1'b0;
      mask_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      ph_q    <= ph_n;
      ident_q <= ident_n;
      start_q <= start_n;
      erase_q <= erase_n;
      mask_q  <= mask_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
    end
  end

  always_comb begin
    case (ph_q)
      PH_PROG_BUSY: src = SRC_PROG;
      PH_ERS_BUSY:  src = SRC_ERASE;
      PH_ERS_SUSP:  src = SRC_SUSP;
      default:      src = ident_q ? SRC_IDENT : SRC_ARRAY;
    endcase
  end

  fcd_window_timer #(.LIMIT(WINDOW_CYC)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ph_q == PH_WINDOW),
    .restart (win_restart),
    .expired (win_expired)
  );

  fcd_busy_engine #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_n),
    .kind_erase (erase_n),
    .pause      (ph_q == PH_ERS_SUSP),
    .abort      (abort),
    .busy       (eng_busy_w),
    .done       (eng_done_w)
  );

  fcd_read_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .NSECT(NSECT)) u_rmux (
    .src       (src),
    .rd_addr   (rd_addr),
    .arr_rdata (arr_rdata),
    .prog_bit7 (data_q[7]),
    .mask      (mask_q),
    .rd_data   (rd_data)
  );

  assign eng_start       = start_q;
  assign eng_erase       = erase_q;
  assign eng_sector_mask = mask_q;
  assign eng_addr        = addr_q;
  assign eng_data        = data_q;
  assign eng_hold        = (ph_q == PH_ERS_SUSP);
  assign eng_busy        = eng_busy_w;
  assign eng_done        = eng_done_w;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rd_data,
  input logic             eng_start,
  input logic             eng_erase,
  input logic [NSECT-1:0] eng_sector_mask,
  input logic [7:0]       eng_data,
  input logic             eng_hold,
  input logic             eng_busy,
  input logic             eng_done
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) eng_start |-> eng_busy); // R4
  AST_ERASE_HAS_SECTOR: assert property (@(posedge clk) disable iff (!rst_n) (eng_start && eng_erase) |-> (eng_sector_mask != '0)); // R7
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) eng_done |=> !eng_busy); // R5
  AST_PROG_POLL_BIT: assert property (@(posedge clk) disable iff (!rst_n) (eng_busy && !eng_erase) |-> (rd_data[7] == ~eng_data[7])); // R5
  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (eng_busy && eng_erase && !eng_hold) |-> (rd_data == 8'h00)); // R9
  AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) eng_hold |-> (eng_busy && !eng_done)); // R10
endmodule

bind flash_cmd_decoder fcd_checker #(.NSECT(1 << SECT_W)) u_fcd_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .rd_data         (rd_data),
  .eng_start       (eng_start),
  .eng_erase       (eng_erase),
  .eng_sector_mask (eng_sector_mask),
  .eng_data        (eng_data),
  .eng_hold        (eng_hold),
  .eng_busy        (eng_busy),
  .eng_done        (eng_done)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 8;
  localparam int PCYC = 6;
  localparam int ECYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [18:0] rd_addr = '0;
  logic [7:0]  arr_rdata = 8'h5A;
  logic [7:0]  rd_data;
  logic        eng_start, eng_erase, eng_hold, eng_busy, eng_done;
  logic [7:0]  eng_sector_mask;
  logic [18:0] eng_addr;
  logic [7:0]  eng_data;

  int n_run = 0;
  int n_fail = 0;
  int done_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(19), .SECT_W(3), .WINDOW_CYC(WIN), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
    .eng_start(eng_start), .eng_erase(eng_erase), .eng_sector_mask(eng_sector_mask),
    .eng_addr(eng_addr), .eng_data(eng_data), .eng_hold(eng_hold),
    .eng_busy(eng_busy), .eng_done(eng_done)
  );

  always @(negedge clk) if (eng_done) done_seen++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wr_addr = a;
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h0AAAA, 8'hAA);
    wr(19'h05554, 8'h55);
  endtask

  task automatic cmd(input logic [7:0] d);
    unlock();
    wr(19'h0AAAA, d);
  endtask

  task automatic sector_first(input logic [18:0] a);
    cmd(8'h80);
    unlock();
    wr(a, 8'h30);
  endtask

  task automatic t_reset();
    arr_rdata = 8'h5A;
    chk("R1", "rd_data", rd_data, 8'h5A);
    chk("R1", "busy", eng_busy, 0);
    chk("R1", "start", eng_start, 0);
    chk("R1", "hold", eng_hold, 0);
    chk("R1", "mask", eng_sector_mask, 0);
  endtask

  task automatic t_bad_unlock();
    wr(19'h0AAAA, 8'hAA);
    wr(19'h01234, 8'h55);
    wr(19'h0AAAA, 8'hA0);
    wr(19'h00100, 8'h11);
    chk("R2", "no start after broken prefix", eng_busy, 0);
    chk("R2", "read mode kept", rd_data, arr_rdata);
  endtask

  task automatic t_ident();
    unlock();
    wr(19'h1AAAA, 8'h90);
    rd_addr = 19'h00000; #1;
    chk("R3", "maker code", rd_data, 8'h01);
    rd_addr = 19'h00002; #1;
    chk("R3", "part code", rd_data, 8'hA4);
    rd_addr = 19'h00004; #1;
    chk("R3", "other offset", rd_data, 8'h00);
    wr(19'h0AAAA, 8'hAA);
    wr(19'h05554, 8'h12);
    rd_addr = 19'h00000; #1;
    chk("R3", "broken prefix keeps ident", rd_data, 8'h01);
    cmd(8'hF0);
    chk("R3", "reset leaves ident", rd_data, arr_rdata);
  endtask

  task automatic t_program();
    cmd(8'hA0);
    wr(19'h12345, 8'h3C);
    chk("R4", "start", eng_start, 1);
    chk("R4", "kind", eng_erase, 0);
    chk("R4", "addr", eng_addr, 19'h12345);
    chk("R4", "data", eng_data, 8'h3C);
    chk("R5", "poll bit7", rd_data, 8'h80);
    wr(19'h0AAAA, 8'hAA);
    chk("R5", "write ignored busy", eng_busy, 1);
    chk("R5", "write ignored addr", eng_addr, 19'h12345);
    repeat (PCYC-2) @(negedge clk);
    chk("R5", "done in last cycle", eng_done, 1);
    @(negedge clk);
    chk("R5", "idle after", eng_busy, 0);
    chk("R5", "array read after", rd_data, arr_rdata);
    wr(19'h05554, 8'h55);
    wr(19'h0AAAA, 8'hA0);
    chk("R5", "ignored AA did not count", eng_busy, 0);
  endtask

  task automatic t_chip_erase();
    cmd(8'h80);
    unlock();
    wr(19'h0AAAA, 8'h10);
    chk("R6", "start", eng_start, 1);
    chk("R6", "kind", eng_erase, 1);
    chk("R6", "mask all", eng_sector_mask, 8'hFF);
    chk("R9", "poll low", rd_data, 8'h00);
    repeat (ECYC-1) @(negedge clk);
    chk("R9", "done", eng_done, 1);
    @(negedge clk);
    chk("R9", "idle", eng_busy, 0);
    chk("R9", "array read", rd_data, arr_rdata);
  endtask

  task automatic t_window();
    sector_first(19'h10000);
    repeat (3) @(negedge clk);
    wr(19'h61234, 8'h30);
    chk("R7", "mask two sectors", eng_sector_mask, 8'h42);
    repeat (WIN-1) @(negedge clk);
    chk("R7", "not started early", eng_busy, 0);
    @(negedge clk);
    chk("R7", "start on time", eng_start, 1);
    chk("R7", "erase kind", eng_erase, 1);
    rd_addr = 19'h10020; #1;
    chk("R9", "poll low", rd_data, 8'h00);
    repeat (ECYC) @(negedge clk);
    chk("R9", "finished", eng_busy, 0);
  endtask

  task automatic t_cancel();
    sector_first(19'h30000);
    wr(19'h00000, 8'h55);
    chk("R8", "mask cleared", eng_sector_mask, 0);
    repeat (WIN+2) @(negedge clk);
    chk("R8", "no start", eng_busy, 0);
    chk("R8", "array read", rd_data, arr_rdata);
  endtask

  task automatic t_suspend();
    int seen0;
    sector_first(19'h20000);
    repeat (WIN) @(negedge clk);
    chk("R10", "erase running", eng_busy, 1);
    repeat (3) @(negedge clk);
    wr(19'h00000, 8'hB0);
    chk("R10", "hold", eng_hold, 1);
    arr_rdata = 8'hC7;
    rd_addr = 19'h50010; #1;
    chk("R10", "other sector reads array", rd_data, 8'hC7);
    rd_addr = 19'h20100; #1;
    chk("R10", "erasing sector reads status", rd_data, 8'h00);
    repeat (2*ECYC) @(negedge clk);
    chk("R10", "frozen while held", eng_busy, 1);
    wr(19'h00000, 8'h30);
    chk("R10", "resumed", eng_hold, 0);
    seen0 = done_seen;
    repeat (ECYC) @(negedge clk);
    chk("R10", "completes after resume", done_seen - seen0, 1);
    chk("R10", "idle", eng_busy, 0);
  endtask

  task automatic t_abort();
    int seen0;
    cmd(8'h80);
    unlock();
    wr(19'h0AAAA, 8'h10);
    repeat (3) @(negedge clk);
    wr(19'h00000, 8'hB0);
    wr(19'h00000, 8'hF0);
    chk("R11", "stopped from suspend", eng_busy, 0);
    cmd(8'h80);
    unlock();
    wr(19'h0AAAA, 8'h10);
    seen0 = done_seen;
    repeat (3) @(negedge clk);
    wr(19'h00000, 8'hF0);
    chk("R11", "stopped", eng_busy, 0);
    chk("R11", "array read", rd_data, arr_rdata);
    repeat (ECYC+2) @(negedge clk);
    chk("R11", "no done", done_seen - seen0, 0);
  endtask

  task automatic t_same_cycle();
    sector_first(19'h40000);
    repeat (WIN-1) @(negedge clk);
    wr(19'h70000, 8'h30);
    chk("R12", "no start on collision", eng_busy, 0);
    chk("R12", "both sectors held", eng_sector_mask, 8'h90);
    repeat (WIN-1) @(negedge clk);
    chk("R12", "window restarted", eng_busy, 0);
    @(negedge clk);
    chk("R12", "start after full window", eng_start, 1);
    repeat (ECYC-1) @(negedge clk);
    chk("R12", "done cycle", eng_done, 1);
    wr(19'h00000, 8'hB0);
    chk("R12", "suspend lost to done hold", eng_hold, 0);
    chk("R12", "suspend lost to done busy", eng_busy, 0);
    chk("R12", "array read", rd_data, arr_rdata);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_unlock();
    t_ident();
    t_program();
    t_chip_erase();
    t_window();
    t_cancel();
    t_suspend();
    t_abort();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule